// File: doc/BRIEF.md
# Acknowledge-paced serial card host controller

This block is the host end of a synchronous serial link to a removable card. The link uses an active-low select, a serial clock that rests high, a host-to-card command line, a card-to-host data line and an active-low acknowledge line that only the card drives. A local requester hands over one byte at a time. The controller selects the card, waits a programmable setup time, and clocks the byte out least significant bit first. It gathers the card's reply byte on the same clock edges.

After the eighth bit the controller stops the clock. It then waits for the card's acknowledge pulse before it reports the byte as done. If no pulse arrives within a programmable number of cycles, it reports "no acknowledge"; this is how the requester finds out that no card is present. The select stays low between bytes for as long as the requester wants, so a multi-byte transaction is a run of byte requests followed by an end request. The clock half-period, the setup delay and the timeout are all counted in system-clock cycles, so the nominal 250 kHz rate and the long card-side waits (over a millisecond) come from configuration and not from the RTL.

Top module: `card_bus_host`

## Requirements
- R1: After reset, and after every transaction ends, card_en_no is 1, card_sck_o is 1 and card_cmd_o is 1. req_ready_o is 1 in the idle state.
- R2: A request accepted in the idle state drives card_en_no low on the accepting clock edge. The first falling edge of card_sck_o follows exactly setup_dly_i cycles later (setup_dly_i >= 1).
- R3: During a byte, each low phase and each high phase of card_sck_o lasts exactly half_period_i cycles (half_period_i >= 1).
- R4: The command byte leaves on card_cmd_o least significant bit first. Each bit changes only together with a falling edge of card_sck_o and is stable across the next rising edge.
- R5: card_data_i is sampled on each rising edge of card_sck_o. The first sampled bit becomes bit 0 of rsp_byte_o, which is presented with the one-cycle rsp_valid_o pulse.
- R6: After the eighth rising edge the clock stays high. A response with rsp_noack_o = 0 is produced only after a falling edge on card_ack_ni, which passes through a two-flop synchronizer. No new byte is accepted until that response.
- R7: If no acknowledge falling edge is seen, rsp_valid_o pulses with rsp_noack_o = 1 exactly timeout_i cycles after the eighth rising edge of card_sck_o.
- R8: Acknowledge pulses that arrive while no byte is waiting for one produce no response and change no line.
- R9: Between bytes the select stays low indefinitely with clock and command high. A request accepted then skips the setup delay: card_sck_o falls on the accepting edge.
- R10: end_i between bytes returns card_en_no to 1 on the next edge. end_i takes priority over a simultaneous request, and req_ready_o is 0 while end_i is 1.
- R11: An acknowledge that arrives thousands of cycles after the byte, but within timeout_i, still completes the byte with rsp_noack_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_period_i | input | CNT_W | Serial clock half-period in cycles |
| setup_dly_i | input | CNT_W | Select-to-first-falling-edge delay in cycles |
| timeout_i | input | CNT_W | Acknowledge timeout in cycles |
| req_valid_i | input | 1 | Byte request valid |
| req_ready_o | output | 1 | Byte request accepted when high with req_valid_i |
| req_byte_i | input | 8 | Command byte to send |
| end_i | input | 1 | End transaction (release select) |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_byte_o | output | 8 | Byte received from the card |
| rsp_noack_o | output | 1 | Acknowledge timed out |
| card_en_no | output | 1 | Card select, active low |
| card_sck_o | output | 1 | Serial clock, idles high |
| card_cmd_o | output | 1 | Host-to-card data, idles high |
| card_data_i | input | 1 | Card-to-host data |
| card_ack_ni | input | 1 | Card acknowledge, active low |

## Verification
Assertions check the following on every cycle: the command line never moves on a rising clock edge; idle lines stay high whenever the select is released; a good response always follows a detected acknowledge edge; a timed-out response always follows an expired timer; the clock's first fall after setup waits for the setup timer; and end_i releases the select on the next edge. The bench scenarios cover what needs counted windows and a card model: the exact setup and half-period lengths, the LSB-first order in both directions, the exact timeout latency, a late acknowledge, stray acknowledges between bytes, and end_i winning over a simultaneous request.

// File: rtl/card_bus_pkg.sv
package card_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_WAIT,
    ST_HOLD
  } cb_state_e;
endpackage

// File: rtl/cb_ack_sync.sv
module cb_ack_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_ni,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= ack_ni;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_o = s3_q & ~s2_q;

  // R8: an edge is reported for one cycle only
  a_r8_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/cb_timer.sv
module cb_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  assign done_o = (cnt_q == '0);

  // R3: a loaded nonzero count is not done on the next cycle
  a_r3_load_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && val_i != '0) |=> !done_o);
endmodule

// File: rtl/cb_shift.sv
module cb_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic [BYTE_W-1:0] rx_o
);
  logic [BYTE_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '1;
      rx_q <= '0;
    end else begin
      if (load_i)       tx_q <= byte_i;
      else if (shift_i) tx_q <= {1'b1, tx_q[BYTE_W-1:1]};
      if (sample_i)     rx_q <= {sdi_i, rx_q[BYTE_W-1:1]};
    end
  end

  assign sdo_o = tx_q[0];
  assign rx_o  = rx_q;

  // R4: loading and shifting are never requested together
  a_r4_load_xor_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));
endmodule

// File: rtl/card_bus_host.sv
module card_bus_host
  import card_bus_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  half_period_i,
  input  logic [CNT_W-1:0]  setup_dly_i,
  input  logic [CNT_W-1:0]  timeout_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [BYTE_W-1:0] req_byte_i,
  input  logic              end_i,
  output logic              rsp_valid_o,
  output logic [BYTE_W-1:0] rsp_byte_o,
  output logic              rsp_noack_o,
  output logic              card_en_no,
  output logic              card_sck_o,
  output logic              card_cmd_o,
  input  logic              card_data_i,
  input  logic              card_ack_ni
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  cb_state_e        state_q, state_d;
  logic [BIT_W-1:0] bit_q;
  logic             ph_load, ph_done, tmo_load, tmo_done, ack_fall;
  logic [CNT_W-1:0] ph_val;
  logic             tx_load, tx_shift, rx_sample, bit_clr, bit_inc;
  logic             rsp_set, noack_set, req_fire, sdo;

  assign req_ready_o = ((state_q == ST_IDLE) || (state_q == ST_HOLD)) && !end_i;
  assign req_fire    = req_valid_i && req_ready_o;

  cb_timer #(.CNT_W(CNT_W)) u_phase (
    .clk_i, .rst_ni, .load_i(ph_load), .val_i(ph_val), .done_o(ph_done)
  );

  cb_timer #(.CNT_W(CNT_W)) u_tmo (
    .clk_i, .rst_ni, .load_i(tmo_load), .val_i(dec(timeout_i)), .done_o(tmo_done)
  );

  cb_ack_sync u_ack (
    .clk_i, .rst_ni, .ack_ni(card_ack_ni), .fall_o(ack_fall)
  );

  cb_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .load_i(tx_load), .byte_i(req_byte_i), .shift_i(tx_shift),
    .sample_i(rx_sample), .sdi_i(card_data_i), .sdo_o(sdo), .rx_o(rsp_byte_o)
  );

  always_comb begin
    state_d   = state_q;
    ph_load   = 1'b0;
    ph_val    = dec(half_period_i);
    tmo_load  = 1'b0;
    tx_load   = 1'b0;
    tx_shift  = 1'b0;
    rx_sample = 1'b0;
    bit_clr   = 1'b0;
    bit_inc   = 1'b0;
    rsp_set   = 1'b0;
    noack_set = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_fire) begin
        state_d = ST_SETUP;
        ph_load = 1'b1;
        ph_val  = dec(setup_dly_i);
        tx_load = 1'b1;
        bit_clr = 1'b1;
      end
      ST_SETUP: if (ph_done) begin
        state_d = ST_LOW;
        ph_load = 1'b1;
      end
      ST_LOW: if (ph_done) begin
        rx_sample = 1'b1;
        if (bit_q == LAST_BIT) begin
          state_d  = ST_WAIT;
          tmo_load = 1'b1;
        end else begin
          state_d = ST_HIGH;
          ph_load = 1'b1;
        end
      end
      ST_HIGH: if (ph_done) begin
        state_d  = ST_LOW;
        tx_shift = 1'b1;
        bit_inc  = 1'b1;
        ph_load  = 1'b1;
      end
      ST_WAIT: begin
        if (ack_fall) begin
          state_d = ST_HOLD;
          rsp_set = 1'b1;
        end else if (tmo_done) begin
          state_d   = ST_HOLD;
          rsp_set   = 1'b1;
          noack_set = 1'b1;
        end
      end
      ST_HOLD: begin
        if (end_i) state_d = ST_IDLE;
        else if (req_valid_i) begin
          state_d = ST_LOW;
          tx_load = 1'b1;
          bit_clr = 1'b1;
          ph_load = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_noack_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_o <= rsp_set;
      if (bit_clr)      bit_q <= '0;
      else if (bit_inc) bit_q <= bit_q + 1'b1;
      if (rsp_set)      rsp_noack_o <= noack_set;
    end
  end

  assign card_en_no = (state_q == ST_IDLE);
  assign card_sck_o = (state_q != ST_LOW);
  assign card_cmd_o = (state_q == ST_LOW || state_q == ST_HIGH || state_q == ST_WAIT)
                      ? sdo : 1'b1;

  // R1: a released select always comes with idle-high clock and command
  a_r1_idle_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_en_no |-> (card_sck_o && card_cmd_o));

  // R2: the first clock fall after select waits for the setup timer
  a_r2_setup_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(card_sck_o) && $past(state_q) == ST_SETUP) |-> $past(ph_done));

  // R4: the command line is stable across every rising clock edge
  a_r4_cmd_stable_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_sck_o) |-> $stable(card_cmd_o));

  // R6: a good response needs a detected acknowledge edge
  a_r6_ack_gates_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_noack_o) |-> $past(ack_fall));

  // R7: a timed-out response needs an expired timer
  a_r7_timeout_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_noack_o) |-> $past(tmo_done));

  // R10: end between bytes releases the select on the next edge
  a_r10_end_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && end_i) |=> card_en_no);
endmodule

// File: tb/card_bus_host_tb_top.sv
module card_bus_host_tb_top;
  localparam int CNT_W = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [CNT_W-1:0] half_period, setup_dly, timeout;
  logic       req_valid = 1'b0, end_req = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic       req_ready, rsp_valid, rsp_noack;
  logic [7:0] rsp_byte;
  logic       en_n, sck, cmd;
  logic       card_data = 1'b0;
  logic       card_ack_n = 1'b1;

  card_bus_host #(.CNT_W(CNT_W), .BYTE_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .half_period_i(half_period), .setup_dly_i(setup_dly), .timeout_i(timeout),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_byte_i(req_byte),
    .end_i(end_req), .rsp_valid_o(rsp_valid), .rsp_byte_o(rsp_byte),
    .rsp_noack_o(rsp_noack), .card_en_no(en_n), .card_sck_o(sck),
    .card_cmd_o(cmd), .card_data_i(card_data), .card_ack_ni(card_ack_n)
  );

  int n_tests = 0, n_fail = 0, n_rsp = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // card model
  logic [7:0] card_tx = 8'h00;
  logic [7:0] card_sh = 8'h00;
  logic [2:0] card_bit = 3'd0;
  bit         ack_en = 1'b1;
  int         ack_dly = 30;
  logic [7:0] card_rx_q[$];
  event       byte_done;

  always @(negedge sck) if (en_n === 1'b0) card_data <= card_tx[card_bit];

  always @(posedge sck or posedge en_n) begin
    if (en_n === 1'b1) card_bit <= 3'd0;
    else if (en_n === 1'b0) begin
      card_sh <= {cmd, card_sh[7:1]};
      if (card_bit == 3'd7) begin
        card_rx_q.push_back({cmd, card_sh[7:1]});
        card_bit <= 3'd0;
        -> byte_done;
      end else card_bit <= card_bit + 3'd1;
    end
  end

  initial forever begin
    @(byte_done);
    if (ack_en) begin
      repeat (ack_dly) @(negedge clk);
      card_ack_n = 1'b0;
      repeat (10) @(negedge clk);
      card_ack_n = 1'b1;
    end
  end

  // scoreboard
  typedef struct { logic [7:0] cmd; logic [7:0] tx; bit noack; } exp_t;
  exp_t exp_q[$];

  always @(negedge clk) begin
    if (rst_ni && rsp_valid) begin
      n_rsp++;
      if (exp_q.size() == 0) chk(1'b0, "R8 unexpected response", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(rsp_noack == e.noack, "R6/R7 noack flag", int'(rsp_noack), int'(e.noack));
        if (!e.noack) chk(rsp_byte == e.tx, "R5 received byte", rsp_byte, e.tx);
        if (card_rx_q.size() == 0) chk(1'b0, "R4 card saw no byte", 0, 1);
        else begin
          logic [7:0] got;
          got = card_rx_q.pop_front();
          chk(got == e.cmd, "R4 LSB-first command", got, e.cmd);
        end
      end
    end
  end

  task automatic send_byte(input logic [7:0] c, input logic [7:0] tx,
                           input bit first, input bit exp_noack);
    int n;
    card_tx = tx;
    exp_q.push_back('{cmd: c, tx: tx, noack: exp_noack});
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_byte  = c;
    @(negedge clk);
    req_valid = 1'b0;
    if (first) begin
      chk(en_n == 1'b0, "R2 select low on accept", int'(en_n), 0);
      n = 0;
      while (sck) begin @(negedge clk); n++; end
      chk(n == int'(setup_dly), "R2 setup delay", n, int'(setup_dly));
    end else begin
      chk(sck == 1'b0, "R9 no setup between bytes", int'(sck), 0);
    end
    n = 0;
    while (!sck) begin n++; @(negedge clk); end
    chk(n == int'(half_period), "R3 low phase", n, int'(half_period));
    n = 0;
    while (sck) begin n++; @(negedge clk); end
    chk(n == int'(half_period), "R3 high phase", n, int'(half_period));
    for (int b = 1; b < 8; b++) begin
      while (!sck) @(negedge clk);
      if (b < 7) while (sck) @(negedge clk);
    end
    if (exp_noack) begin
      n = 0;
      while (!rsp_valid) begin @(negedge clk); n++; end
      chk(n == int'(timeout), "R7 timeout latency", n, int'(timeout));
    end else begin
      while (!rsp_valid) @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int r0;
    half_period = 20'd5;
    setup_dly   = 20'd20;
    timeout     = 20'd400;
    repeat (3) @(negedge clk);
    chk(en_n == 1'b1 && sck == 1'b1 && cmd == 1'b1, "R1 reset lines",
        {en_n, sck, cmd}, 3'b111);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 ready after reset",
        {req_ready, rsp_valid}, 2'b10);

    send_byte(8'hA5, 8'h3C, 1'b1, 1'b0);
    send_byte(8'h81, 8'hFF, 1'b0, 1'b0);
    send_byte(8'h00, 8'h01, 1'b0, 1'b0);

    // R9: long idle gap with select held
    repeat (500) @(negedge clk);
    chk(en_n == 1'b0 && sck == 1'b1 && cmd == 1'b1, "R9 hold lines",
        {en_n, sck, cmd}, 3'b011);

    // R8: stray acknowledge between bytes
    r0 = n_rsp;
    card_ack_n = 1'b0;
    repeat (10) @(negedge clk);
    card_ack_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(n_rsp == r0, "R8 stray ack ignored", n_rsp, r0);
    chk(en_n == 1'b0 && sck == 1'b1 && cmd == 1'b1 && req_ready == 1'b1,
        "R8 lines unchanged", {en_n, sck, cmd, req_ready}, 4'b0111);

    // R7: absent card
    ack_en = 1'b0;
    send_byte(8'h5C, 8'h00, 1'b0, 1'b1);
    ack_en = 1'b1;

    // R11: very late acknowledge within timeout
    timeout = 20'd5000;
    ack_dly = 3000;
    send_byte(8'h01, 8'h5A, 1'b0, 1'b0);
    ack_dly = 30;

    // R10: end beats a simultaneous request
    end_req   = 1'b1;
    req_valid = 1'b1;
    req_byte  = 8'hEE;
    #1;
    chk(req_ready == 1'b0, "R10 ready low during end", int'(req_ready), 0);
    @(negedge clk);
    end_req   = 1'b0;
    req_valid = 1'b0;
    chk(en_n == 1'b1 && sck == 1'b1 && cmd == 1'b1, "R10 select released",
        {en_n, sck, cmd}, 3'b111);
    repeat (40) @(negedge clk);
    chk(sck == 1'b1 && card_rx_q.size() == 0, "R10 request dropped",
        card_rx_q.size(), 0);

    // new transaction with other timing
    half_period = 20'd3;
    setup_dly   = 20'd7;
    timeout     = 20'd400;
    send_byte(8'hC3, 8'h96, 1'b1, 1'b0);
    end_req = 1'b1;
    @(negedge clk);
    end_req = 1'b0;
    chk(en_n == 1'b1, "R1 idle after end", int'(en_n), 1);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all responses seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule